// File: doc/BRIEF.md
# Posted Write Merging Buffer

This block sits on the upstream side of a bus bridge. It accepts requests from a simple valid/ready port and holds posted writes in a small ordered queue before it sends them downstream over a port of the same shape. A write is acknowledged upstream as soon as it enters the queue, so the requester does not wait for the downstream side to finish it.

When a memory-space write targets the same 32-bit doubleword as the newest queued entry, and that entry is not yet being offered downstream, the block folds the new write into that entry. The combined entry carries the OR of the byte enables, which can leave gaps such as `0101`. Where lanes overlap, the newer write's bytes win. I/O-space writes are never combined.

A read is held in a single read slot. It is offered downstream only after every write queued ahead of it has left. Upstream stays blocked until the read's response comes back, which makes every read a merge barrier. The downstream response is returned upstream one cycle later.

Top module: `posted_wr_merge`

## Requirements
- R1: While reset is held and right after it, `dn_valid` and `up_rvalid` are 0 and `up_ready` is 1.
- R2: Writes are accepted while `dn_ready` is low. After DEPTH (default 4) entries are allocated, `up_ready` is 0 until an entry leaves. It is 1 again once the queue drains.
- R3: A memory write (`up_io`=0) is folded into the newest entry if that entry is memory space, in the same doubleword (`addr[31:2]` equal), and not the entry currently offered downstream. The folded entry's `be` is the OR of both masks, and a non-contiguous result such as `0101` is issued as is.
- R4: When folding, byte lane i (data bits 8i+7..8i) takes the new write's byte if its `be[i]` is 1. Otherwise it keeps the older byte.
- R5: An I/O write (`up_io`=1) always allocates its own entry, even if it repeats the address of the newest entry.
- R6: A write whose doubleword or space differs from the newest entry allocates a new entry.
- R7: Entries leave in allocation order. While `dn_valid` is 1 and `dn_ready` is 0, every downstream request output stays unchanged.
- R8: A read is offered downstream (`dn_valid`=1, `dn_write`=0) only after all writes queued ahead of it have been transferred.
- R9: A read accepted between two writes to the same doubleword keeps them apart, so they reach downstream as two separate writes.
- R10: From the cycle after a read is accepted, `up_ready` is 0 until the cycle after `dn_rvalid`. The cycle after `dn_rvalid`, `up_rvalid` is 1 for one cycle with `up_rdata` equal to `dn_rdata`. A `dn_rvalid` that arrives while no read is waiting has no effect.
- R11: The entry being offered downstream is never folded into. With one entry queued, a same-doubleword memory write allocates a second entry.
- R12: Downstream memory writes carry a doubleword-aligned address (bits 1:0 zero). I/O writes and reads carry their upstream address unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Upstream request accepted this cycle if valid |
| up_addr | input | 32 | Upstream byte address |
| up_io | input | 1 | 1 = I/O space, 0 = memory space |
| up_write | input | 1 | 1 = write, 0 = read |
| up_be | input | 4 | Upstream byte enables, bit i = lane i |
| up_data | input | 32 | Upstream write data |
| up_rvalid | output | 1 | Read response valid, one-cycle pulse |
| up_rdata | output | 32 | Read response data |
| dn_valid | output | 1 | Downstream request valid |
| dn_ready | input | 1 | Downstream accepts request |
| dn_addr | output | 32 | Downstream address |
| dn_io | output | 1 | Downstream space, 1 = I/O |
| dn_write | output | 1 | Downstream direction, 1 = write |
| dn_be | output | 4 | Downstream byte enables |
| dn_data | output | 32 | Downstream write data, zero for reads |
| dn_rvalid | input | 1 | Downstream read response valid |
| dn_rdata | input | 32 | Downstream read response data |

## Verification
A wrong fold decision or a corrupted lane shows as an extra, missing or mis-masked write the first time the queue drains after the faulty cycle. That is a few cycles after `dn_ready` rises. Pointer or count damage shows at once on `up_ready` at the full boundary, or as an out-of-order entry on the downstream port. A slip in the read slot shows as a read overtaking a queued write, or as upstream staying blocked or unblocking one cycle off the `dn_rvalid` pulse.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned PWM_AW  = 32;
    localparam int unsigned PWM_DW  = 32;
    localparam int unsigned PWM_BW  = PWM_DW / 8;
    localparam int unsigned PWM_OFS = $clog2(PWM_BW);

    typedef struct packed {
        logic [PWM_AW-1:0] addr;
        logic              io;
        logic [PWM_BW-1:0] be;
        logic [PWM_DW-1:0] data;
    } pwm_ent_t;
endpackage

// File: rtl/pwm_fifo.sv
module pwm_fifo
    import pwm_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  pwm_ent_t          push_ent,
    input  logic              merge,
    input  logic [PWM_BW-1:0] merge_be,
    input  logic [PWM_DW-1:0] merge_data,
    input  logic              pop,
    output pwm_ent_t          head,
    output pwm_ent_t          tail,
    output logic [CW-1:0]     count
);
    typedef struct packed {
        pwm_ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [CW-1:0]        cnt;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [PW-1:0] tail_idx;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        tail_idx = (st_q.wp == '0) ? PW'(DEPTH - 1) : st_q.wp - PW'(1);
        st_d     = st_q;
        if (merge) begin
            st_d.mem[tail_idx].be   = merge_be;
            st_d.mem[tail_idx].data = merge_data;
        end
        if (push) begin
            st_d.mem[st_q.wp] = push_ent;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (pop) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rp];
    assign tail  = st_q.mem[tail_idx];
    assign count = st_q.cnt;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt < CW'(DEPTH)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (st_q.cnt != '0));

    // R11
    merge_not_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> (st_q.cnt >= CW'(2)));
endmodule

// File: rtl/pwm_merge_ctl.sv
module pwm_merge_ctl
    import pwm_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              wr_fire,
    input  pwm_ent_t          up_ent,
    input  pwm_ent_t          tail,
    input  logic [CW-1:0]     count,
    output logic              push,
    output logic              merge,
    output logic [PWM_BW-1:0] merge_be,
    output logic [PWM_DW-1:0] merge_data
);
    logic [PWM_AW-1:0] addr_diff;
    logic              same_dw;
    logic              tail_open;

    always_comb begin
        addr_diff = up_ent.addr ^ tail.addr;
        same_dw   = ((addr_diff >> PWM_OFS) == '0);
        tail_open = (count >= CW'(2));
        merge     = wr_fire && !up_ent.io && !tail.io && same_dw && tail_open;
        push      = wr_fire && !merge;
        merge_be  = tail.be | up_ent.be;
    end

    for (genvar i = 0; i < PWM_BW; i++) begin : g_lane
        assign merge_data[8*i +: 8] = up_ent.be[i] ? up_ent.data[8*i +: 8]
                                                   : tail.data[8*i +: 8];
    end
endmodule

// File: rtl/pwm_rd_slot.sv
module pwm_rd_slot
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_accept,
    input  logic [PWM_AW-1:0] up_addr,
    input  logic              up_io,
    input  logic [PWM_BW-1:0] up_be,
    input  logic              fifo_empty,
    input  logic              dn_ready,
    input  logic              dn_rvalid,
    input  logic [PWM_DW-1:0] dn_rdata,
    output logic              rd_present,
    output logic              rd_busy,
    output logic [PWM_AW-1:0] rd_addr,
    output logic              rd_io,
    output logic [PWM_BW-1:0] rd_be,
    output logic              up_rvalid,
    output logic [PWM_DW-1:0] up_rdata
);
    typedef struct packed {
        logic              pend;
        logic              wt;
        logic [PWM_AW-1:0] addr;
        logic              io;
        logic [PWM_BW-1:0] be;
        logic              rvalid;
        logic [PWM_DW-1:0] rdata;
    } rd_st_t;

    rd_st_t rs_d, rs_q;
    logic   issue;

    always_comb begin
        rs_d      = rs_q;
        rs_d.rvalid = 1'b0;
        issue     = rs_q.pend && fifo_empty && dn_ready;
        if (rd_accept) begin
            rs_d.pend = 1'b1;
            rs_d.addr = up_addr;
            rs_d.io   = up_io;
            rs_d.be   = up_be;
        end
        if (issue) begin
            rs_d.pend = 1'b0;
            rs_d.wt   = 1'b1;
        end
        if (rs_q.wt && dn_rvalid) begin
            rs_d.wt     = 1'b0;
            rs_d.rvalid = 1'b1;
            rs_d.rdata  = dn_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rd_present = rs_q.pend && fifo_empty;
    assign rd_busy    = rs_q.pend || rs_q.wt;
    assign rd_addr    = rs_q.addr;
    assign rd_io      = rs_q.io;
    assign rd_be      = rs_q.be;
    assign up_rvalid  = rs_q.rvalid;
    assign up_rdata   = rs_q.rdata;

    // R10
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |-> !(rs_q.pend || rs_q.wt));
endmodule

// File: rtl/posted_wr_merge.sv
module posted_wr_merge
    import pwm_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [PWM_AW-1:0] up_addr,
    input  logic              up_io,
    input  logic              up_write,
    input  logic [PWM_BW-1:0] up_be,
    input  logic [PWM_DW-1:0] up_data,
    output logic              up_rvalid,
    output logic [PWM_DW-1:0] up_rdata,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [PWM_AW-1:0] dn_addr,
    output logic              dn_io,
    output logic              dn_write,
    output logic [PWM_BW-1:0] dn_be,
    output logic [PWM_DW-1:0] dn_data,
    input  logic              dn_rvalid,
    input  logic [PWM_DW-1:0] dn_rdata
);
    localparam logic [PWM_AW-1:0] DW_MASK = {{(PWM_AW - PWM_OFS){1'b1}}, {PWM_OFS{1'b0}}};

    pwm_ent_t          up_ent, head, tail;
    logic [CW-1:0]     count;
    logic              fifo_empty, up_fire, wr_fire, rd_accept;
    logic              push, merge, pop;
    logic [PWM_BW-1:0] merge_be;
    logic [PWM_DW-1:0] merge_data;
    logic              rd_present, rd_busy, rd_io;
    logic [PWM_AW-1:0] rd_addr;
    logic [PWM_BW-1:0] rd_be;

    always_comb begin
        up_ent     = '{addr: up_addr, io: up_io, be: up_be, data: up_data};
        fifo_empty = (count == '0);
        up_ready   = !rd_busy && (count < CW'(DEPTH));
        up_fire    = up_valid && up_ready;
        wr_fire    = up_fire && up_write;
        rd_accept  = up_fire && !up_write;
        pop        = !fifo_empty && dn_ready;
        if (!fifo_empty) begin
            dn_valid = 1'b1;
            dn_write = 1'b1;
            dn_addr  = head.io ? head.addr : (head.addr & DW_MASK);
            dn_io    = head.io;
            dn_be    = head.be;
            dn_data  = head.data;
        end else begin
            dn_valid = rd_present;
            dn_write = 1'b0;
            dn_addr  = rd_addr;
            dn_io    = rd_io;
            dn_be    = rd_be;
            dn_data  = '0;
        end
    end

    pwm_merge_ctl #(.DEPTH(DEPTH)) u_ctl (
        .wr_fire    (wr_fire),
        .up_ent     (up_ent),
        .tail       (tail),
        .count      (count),
        .push       (push),
        .merge      (merge),
        .merge_be   (merge_be),
        .merge_data (merge_data)
    );

    pwm_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_ent   (up_ent),
        .merge      (merge),
        .merge_be   (merge_be),
        .merge_data (merge_data),
        .pop        (pop),
        .head       (head),
        .tail       (tail),
        .count      (count)
    );

    pwm_rd_slot u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_accept  (rd_accept),
        .up_addr    (up_addr),
        .up_io      (up_io),
        .up_be      (up_be),
        .fifo_empty (fifo_empty),
        .dn_ready   (dn_ready),
        .dn_rvalid  (dn_rvalid),
        .dn_rdata   (dn_rdata),
        .rd_present (rd_present),
        .rd_busy    (rd_busy),
        .rd_addr    (rd_addr),
        .rd_io      (rd_io),
        .rd_be      (rd_be),
        .up_rvalid  (up_rvalid),
        .up_rdata   (up_rdata)
    );

    // R7
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_addr) && $stable(dn_io)
            && $stable(dn_write) && $stable(dn_be) && $stable(dn_data)));

    // R8
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_present |-> (count == '0));

    // R10
    rd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_accept |=> !up_ready);

    // R5
    io_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        merge |-> !up_io);
endmodule

// File: tb/posted_wr_merge_bench.sv
module posted_wr_merge_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        up_valid, up_ready, up_io, up_write, up_rvalid;
    logic [31:0] up_addr, up_data, up_rdata;
    logic [3:0]  up_be;
    logic        dn_valid, dn_ready, dn_io, dn_write, dn_rvalid;
    logic [31:0] dn_addr, dn_data, dn_rdata;
    logic [3:0]  dn_be;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    posted_wr_merge u_posted_wr_merge (
        .clk(clk), .rst_n(rst_n),
        .up_valid(up_valid), .up_ready(up_ready), .up_addr(up_addr), .up_io(up_io),
        .up_write(up_write), .up_be(up_be), .up_data(up_data),
        .up_rvalid(up_rvalid), .up_rdata(up_rdata),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_addr(dn_addr), .dn_io(dn_io),
        .dn_write(dn_write), .dn_be(dn_be), .dn_data(dn_data),
        .dn_rvalid(dn_rvalid), .dn_rdata(dn_rdata)
    );

    // vector layout {io, be[3:0], addr[31:0], data[31:0]}
    localparam logic [68:0] A_IN [6] = '{
        {1'b0, 4'b0001, 32'h0000_1000, 32'h0000_00AA},
        {1'b0, 4'b0100, 32'h0000_1002, 32'h00BB_0000},
        {1'b0, 4'b0001, 32'h0000_1000, 32'h0000_00CC},
        {1'b0, 4'b0011, 32'h0000_1001, 32'h0000_DDEE},
        {1'b1, 4'b1000, 32'h0000_1003, 32'h1100_0000},
        {1'b1, 4'b1000, 32'h0000_1003, 32'h2200_0000}
    };
    localparam logic [68:0] A_EXP [4] = '{
        {1'b0, 4'b0001, 32'h0000_1000, 32'h0000_00AA},
        {1'b0, 4'b0111, 32'h0000_1000, 32'h00BB_DDEE},
        {1'b1, 4'b1000, 32'h0000_1003, 32'h1100_0000},
        {1'b1, 4'b1000, 32'h0000_1003, 32'h2200_0000}
    };
    localparam string A_TAG [4] = '{"R12 R11", "R3 R4 R11", "R6", "R5"};

    localparam logic [68:0] B_EXP [4] = '{
        {1'b0, 4'b0001, 32'h0000_2000, 32'h0000_00AA},
        {1'b0, 4'b0011, 32'h0000_2004, 32'h0000_2211},
        {1'b0, 4'b0001, 32'h0000_2008, 32'h0000_0055},
        {1'b0, 4'b1111, 32'h0000_2000, 32'h0000_0000}
    };

    task automatic chk(input string tag, input logic [68:0] act, input logic [68:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [68:0] dn_vec();
        return {dn_io, dn_be, dn_addr, dn_data};
    endfunction

    task automatic send(input logic wr, input logic [68:0] v);
        up_valid = 1'b1;
        up_write = wr;
        {up_io, up_be, up_addr, up_data} = v;
        while (!up_ready) @(negedge clk);
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; up_valid = 0; up_io = 0; up_write = 0; up_be = 0;
        up_addr = 0; up_data = 0; dn_ready = 0; dn_rvalid = 0; dn_rdata = 0;
        repeat (3) @(negedge clk);
        chk("R1 dn_valid in reset", 69'(dn_valid), 69'(0));
        chk("R1 up_rvalid in reset", 69'(up_rvalid), 69'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 up_ready after reset", 69'(up_ready), 69'(1));

        // table walk: fill while stalled, then drain
        for (int i = 0; i < 6; i++) send(1'b1, A_IN[i]);
        chk("R2 full blocks upstream", 69'(up_ready), 69'(0));
        chk("R7 head offered", 69'(dn_valid), 69'(1));
        repeat (3) @(negedge clk);
        chk("R7 head held under stall", dn_vec(), A_EXP[0]);
        dn_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            while (!dn_valid) @(negedge clk);
            chk({A_TAG[k], " R7 drained entry"}, dn_vec(), A_EXP[k]);
            chk("R7 drained entry is write", 69'(dn_write), 69'(1));
            @(negedge clk);
        end
        dn_ready = 1'b0;
        chk("R2 ready after drain", 69'(up_ready), 69'(1));
        chk("R7 queue empty after drain", 69'(dn_valid), 69'(0));

        // directed: read ordering and barrier
        send(1'b1, {1'b0, 4'b0001, 32'h0000_2000, 32'h0000_00AA});
        send(1'b1, {1'b0, 4'b0001, 32'h0000_2004, 32'h0000_0011});
        send(1'b1, {1'b0, 4'b0010, 32'h0000_2005, 32'h0000_2200});
        send(1'b1, {1'b0, 4'b0001, 32'h0000_2009, 32'h0000_0055});
        send(1'b0, {1'b0, 4'b1111, 32'h0000_2000, 32'h0000_0000});
        chk("R10 blocked after read", 69'(up_ready), 69'(0));
        chk("R8 write still ahead of read", {68'(0), dn_write}, 69'(1));
        dn_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            while (!dn_valid) @(negedge clk);
            if (k < 3) begin
                chk("R6 R8 write before read", dn_vec(), B_EXP[k]);
                chk("R8 direction write", 69'(dn_write), 69'(1));
            end else begin
                chk("R8 read after writes", {dn_io, dn_be, dn_addr, 32'h0}, B_EXP[k]);
                chk("R8 direction read", 69'(dn_write), 69'(0));
            end
            @(negedge clk);
        end
        dn_ready = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10 still blocked awaiting response", 69'(up_ready), 69'(0));
        dn_rvalid = 1'b1; dn_rdata = 32'hCAFE_F00D;
        @(negedge clk);
        dn_rvalid = 1'b0; dn_rdata = 32'h0;
        chk("R10 response valid", 69'(up_rvalid), 69'(1));
        chk("R10 response data", 69'(up_rdata), 69'(32'hCAFE_F00D));
        chk("R10 ready after response", 69'(up_ready), 69'(1));
        @(negedge clk);
        chk("R10 response is one pulse", 69'(up_rvalid), 69'(0));
        dn_rvalid = 1'b1; dn_rdata = 32'h1234_5678;
        @(negedge clk);
        dn_rvalid = 1'b0;
        chk("R10 stray response ignored", 69'(up_rvalid), 69'(0));

        send(1'b1, {1'b0, 4'b0100, 32'h0000_2006, 32'h0033_0000});
        chk("R9 post-read write stands alone",
            dn_vec(), {1'b0, 4'b0100, 32'h0000_2004, 32'h0033_0000});
        dn_ready = 1'b1;
        @(negedge clk);
        chk("R9 nothing else queued", 69'(dn_valid), 69'(0));
        dn_ready = 1'b0;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule